// File: doc/BRIEF.md
# Hidden Configuration Bank Unlock Gate

This block sits on the host side of an IDE task-file register window. It watches every host access (strobe, direction, width, 3-bit register offset and the low data byte) and looks for a fixed unlock sequence. The sequence has three accesses in order. First come two consecutive 16-bit reads at offset 1. Then comes an 8-bit write of 0x03 at offset 2. When the sequence completes, the block switches into configuration mode.

In configuration mode the same eight offsets no longer reach the normal task-file registers. They decode to a hidden bank instead. Offset 0 holds read-cycle timing and offset 1 holds write-cycle timing. Offset 3 is a control byte: 0x95 enables and 0x11 disables. Offset 5 is a read-only strap whose bit 0 is the bus-speed pin latched during reset (0 = 33 MHz, 1 = 25 MHz). Offset 6 is a miscellaneous byte with seven writable bits. An 8-bit write of 0x83 at offset 2 leaves the mode.

Outside configuration mode the block only raises a passthrough select toward the normal registers. The accesses that make up the unlock sequence are passed through as well.

Top module: `hcfg_gate`

## Requirements
- R1: After reset, configuration mode is off. The hidden bank holds these values: read timing 0xFF, write timing 0xFF, control 0x11, misc 0x00, strap = {7'b0, speed pin level during reset}.
- R2: Configuration mode starts in the cycle after an 8-bit write of 0x03 at offset 2. That write must immediately follow at least two back-to-back 16-bit reads at offset 1 (acc_wide_i=1 means 16-bit). If more than two such reads come in a row, the sequence still counts as complete.
- R3: Any access that is not the expected next step returns the detector to its start. Examples are an 8-bit read at offset 1, another offset, or a wrong key byte. A key write afterwards then does not enter the mode.
- R4: While configuration mode is off, every access asserts pass_sel_o, keeps hid_we_o at zero and reads hid_rdata_o as zero. This includes the accesses of the unlock sequence.
- R5: In configuration mode, pass_sel_o is low. Offsets 0, 1 and 3 are full read/write bytes taken from the low data byte of a write. A read returns the stored byte in the same cycle as the access.
- R6: In configuration mode, offset 5 reads the strap byte, and writes to it change nothing.
- R7: In configuration mode, offset 6 stores only bits 6:0 of a write, and bit 7 always reads 0.
- R8: In configuration mode, an 8-bit write of 0x83 at offset 2 turns the mode off from the next cycle. Any other write at offset 2, including a 16-bit 0x83, leaves the mode on.
- R9: In configuration mode, writes at offsets 2, 4 and 7 store nothing, and reads at those offsets return 0x00.
- R10: hid_we_o bit n is high exactly during a configuration-mode write at offset n, for n in {0, 1, 3, 6}. At most one bit is ever high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; the speed pin is latched while low |
| speed_pin_i | input | 1 | Bus-speed strap pin (0 = 33 MHz, 1 = 25 MHz) |
| acc_valid_i | input | 1 | Host access strobe, one access per cycle |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_wide_i | input | 1 | 1 = 16-bit access, 0 = 8-bit access |
| acc_off_i | input | 3 | Register offset within the window |
| acc_wdata_i | input | 8 | Low byte of write data |
| cfg_mode_o | output | 1 | Configuration mode active |
| pass_sel_o | output | 1 | Access goes to the normal task-file registers |
| hid_rdata_o | output | 8 | Hidden-register read data, zero when not a hidden read |
| hid_we_o | output | 8 | Per-offset hidden-register write enable |

## Verification
The two functions that can meet in one cycle are mode entry or exit and the decode of the access at the same edge. The key write at offset 2 must still pass through, while the next access must already be redirected. Likewise, the exit write must be consumed as hidden while the following access passes through again. The bench provokes both with back-to-back accesses and no idle cycle between them. A scoreboard predicts passthrough, read data, write enables and mode for every access from a reference model of the requirements, and compares them with the outputs seen in that access's cycle.

// File: rtl/hcfg_pkg.sv
package hcfg_pkg;

    localparam int OFF_W    = 3;
    localparam int REG_W    = 8;
    localparam int NUM_OFF  = 1 << OFF_W;

    // offsets decoded by the detector and the hidden bank
    localparam int OFF_UNLOCK = 1;
    localparam int OFF_KEY    = 2;
    localparam int OFF_RDTIM  = 0;
    localparam int OFF_WRTIM  = 1;
    localparam int OFF_CTRL   = 3;
    localparam int OFF_STRAP  = 5;
    localparam int OFF_MISC   = 6;

    localparam logic [REG_W-1:0] KEY_ENTER = 8'h03;
    localparam logic [REG_W-1:0] KEY_EXIT  = 8'h83;
    localparam logic [REG_W-1:0] CTRL_ON   = 8'h95;
    localparam logic [REG_W-1:0] CTRL_OFF  = 8'h11;

    // writable bits of each hidden offset (zero = no writable storage)
    function automatic logic [REG_W-1:0] wr_mask(input int idx);
        case (idx)
            OFF_RDTIM, OFF_WRTIM, OFF_CTRL: wr_mask = 8'hFF;
            OFF_MISC:                       wr_mask = 8'h7F;
            default:                        wr_mask = 8'h00;
        endcase
    endfunction

    function automatic logic [REG_W-1:0] rst_val(input int idx);
        case (idx)
            OFF_RDTIM, OFF_WRTIM: rst_val = 8'hFF;
            OFF_CTRL:             rst_val = CTRL_OFF;
            default:              rst_val = 8'h00;
        endcase
    endfunction

    typedef struct packed {
        logic       mode;
        logic [1:0] rd_cnt;
    } det_state_t;

endpackage

// File: rtl/hcfg_detect.sv
module hcfg_detect
    import hcfg_pkg::*;
#(
    parameter int READS_NEEDED = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid_i,
    input  logic             acc_write_i,
    input  logic             acc_wide_i,
    input  logic [OFF_W-1:0] acc_off_i,
    input  logic [REG_W-1:0] acc_wdata_i,
    output logic             mode_o
);

    localparam logic [1:0] CNT_FULL = 2'(READS_NEEDED);

    det_state_t st_d, st_q;

    logic unlock_rd, key_wr, enter_hit, exit_hit;

    always_comb begin
        unlock_rd = acc_valid_i && !acc_write_i && acc_wide_i
                    && (acc_off_i == OFF_W'(OFF_UNLOCK));
        key_wr    = acc_valid_i && acc_write_i && !acc_wide_i
                    && (acc_off_i == OFF_W'(OFF_KEY));
        enter_hit = key_wr && (acc_wdata_i == KEY_ENTER) && (st_q.rd_cnt == CNT_FULL);
        exit_hit  = key_wr && (acc_wdata_i == KEY_EXIT);

        st_d = st_q;
        if (st_q.mode) begin
            st_d.rd_cnt = '0;
            if (exit_hit) st_d.mode = 1'b0;
        end else if (acc_valid_i) begin
            if (unlock_rd) begin
                if (st_q.rd_cnt != CNT_FULL) st_d.rd_cnt = st_q.rd_cnt + 2'd1;
            end else if (enter_hit) begin
                st_d.mode   = 1'b1;
                st_d.rd_cnt = '0;
            end else begin
                st_d.rd_cnt = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mode_o = st_q.mode;

    p_enter_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.mode && key_wr && acc_wdata_i == KEY_ENTER && st_q.rd_cnt == CNT_FULL)
        |=> st_q.mode);

    p_break_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.mode && acc_valid_i && !unlock_rd) |=> (st_q.rd_cnt == 2'd0));

    p_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode && exit_hit) |=> !st_q.mode);

    p_stay_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode && !exit_hit) |=> st_q.mode);

endmodule

// File: rtl/hcfg_bank.sv
module hcfg_bank
    import hcfg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               speed_pin_i,
    input  logic               sel_i,
    input  logic               write_i,
    input  logic [OFF_W-1:0]   off_i,
    input  logic [REG_W-1:0]   wdata_i,
    output logic [REG_W-1:0]   rdata_o,
    output logic [NUM_OFF-1:0] we_o
);

    logic [REG_W-1:0] reg_q [NUM_OFF];

    genvar gi;
    generate
        for (gi = 0; gi < NUM_OFF; gi++) begin : g_reg
            localparam logic [REG_W-1:0] MASK = wr_mask(gi);
            localparam logic [REG_W-1:0] RSTV = rst_val(gi);
            if (gi == OFF_STRAP) begin : g_strap
                logic strap_d, strap_q;
                always_comb strap_d = rst_n ? strap_q : speed_pin_i;
                always_ff @(posedge clk) strap_q <= strap_d;
                assign reg_q[gi] = {{(REG_W-1){1'b0}}, strap_q};
                assign we_o[gi]  = 1'b0;
                p_strap_ro_r6: assert property (@(posedge clk) disable iff (!rst_n)
                    $past(rst_n) |-> $stable(strap_q));
            end else if (MASK != '0) begin : g_rw
                logic [REG_W-1:0] val_d, val_q;
                logic             hit;
                always_comb begin
                    hit   = sel_i && write_i && (off_i == OFF_W'(gi));
                    val_d = val_q;
                    if (hit) val_d = wdata_i & MASK;
                end
                always_ff @(posedge clk) begin
                    if (!rst_n) val_q <= RSTV;
                    else        val_q <= val_d;
                end
                assign reg_q[gi] = val_q;
                assign we_o[gi]  = hit;
                p_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
                    (val_q & ~MASK) == '0);
            end else begin : g_none
                assign reg_q[gi] = '0;
                assign we_o[gi]  = 1'b0;
            end
        end
    endgenerate

    always_comb begin
        rdata_o = '0;
        if (sel_i && !write_i) rdata_o = reg_q[off_i];
    end

    p_we_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(we_o));

    p_we_sel_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|we_o) |-> (sel_i && write_i));

endmodule

// File: rtl/hcfg_gate.sv
module hcfg_gate
    import hcfg_pkg::*;
#(
    parameter int READS_NEEDED = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               speed_pin_i,
    input  logic               acc_valid_i,
    input  logic               acc_write_i,
    input  logic               acc_wide_i,
    input  logic [OFF_W-1:0]   acc_off_i,
    input  logic [REG_W-1:0]   acc_wdata_i,
    output logic               cfg_mode_o,
    output logic               pass_sel_o,
    output logic [REG_W-1:0]   hid_rdata_o,
    output logic [NUM_OFF-1:0] hid_we_o
);

    logic mode;
    logic hid_sel;

    hcfg_detect #(.READS_NEEDED(READS_NEEDED)) u_detect (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_valid_i (acc_valid_i),
        .acc_write_i (acc_write_i),
        .acc_wide_i  (acc_wide_i),
        .acc_off_i   (acc_off_i),
        .acc_wdata_i (acc_wdata_i),
        .mode_o      (mode)
    );

    assign hid_sel    = acc_valid_i && mode;
    assign pass_sel_o = acc_valid_i && !mode;
    assign cfg_mode_o = mode;

    hcfg_bank u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .speed_pin_i (speed_pin_i),
        .sel_i       (hid_sel),
        .write_i     (acc_write_i),
        .off_i       (acc_off_i),
        .wdata_i     (acc_wdata_i),
        .rdata_o     (hid_rdata_o),
        .we_o        (hid_we_o)
    );

    p_pass_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pass_sel_o |-> (!cfg_mode_o && hid_we_o == '0 && hid_rdata_o == '0));

endmodule

// File: tb/tb_hcfg_gate.sv
module tb_hcfg_gate;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       speed_pin = 1'b1;
    logic       acc_valid = 1'b0, acc_write = 1'b0, acc_wide = 1'b0;
    logic [2:0] acc_off = '0;
    logic [7:0] acc_wdata = '0;
    logic       cfg_mode, pass_sel;
    logic [7:0] hid_rdata, hid_we;

    always #5 clk = ~clk;

    hcfg_gate dut (
        .clk(clk), .rst_n(rst_n), .speed_pin_i(speed_pin),
        .acc_valid_i(acc_valid), .acc_write_i(acc_write), .acc_wide_i(acc_wide),
        .acc_off_i(acc_off), .acc_wdata_i(acc_wdata),
        .cfg_mode_o(cfg_mode), .pass_sel_o(pass_sel),
        .hid_rdata_o(hid_rdata), .hid_we_o(hid_we)
    );

    typedef struct {
        logic       pass;
        logic       mode;
        logic [7:0] rdata;
        logic [7:0] we;
        string      tag;
    } exp_t;

    exp_t q[$];
    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    // reference model of the requirements
    bit       m_mode = 0;
    int       m_cnt = 0;
    logic [7:0] m_reg [8];

    function automatic logic [7:0] mask_of(input int o);
        if (o == 0 || o == 1 || o == 3) return 8'hFF;
        if (o == 6) return 8'h7F;
        return 8'h00;
    endfunction

    task automatic acc(input bit w, input bit wide, input int off,
                       input logic [7:0] d, input string tag);
        exp_t e;
        @(negedge clk);
        acc_valid = 1; acc_write = w; acc_wide = wide;
        acc_off = 3'(off); acc_wdata = d;
        e.tag = tag; e.mode = m_mode; e.rdata = 8'h00; e.we = 8'h00;
        if (!m_mode) begin
            e.pass = 1;
            if (!w && wide && off == 1) begin
                if (m_cnt < 2) m_cnt++;
            end else if (w && !wide && off == 2 && d == 8'h03 && m_cnt == 2) begin
                m_mode = 1; m_cnt = 0;
            end else m_cnt = 0;
        end else begin
            e.pass = 0;
            if (w) begin
                if (mask_of(off) != 0) begin
                    e.we[off] = 1'b1;
                    m_reg[off] = d & mask_of(off);
                end
                if (off == 2 && !wide && d == 8'h83) m_mode = 0;
            end else e.rdata = m_reg[off];
        end
        q.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk);
        acc_valid = 0; acc_write = 0;
    endtask

    // monitor: compares each access in its own cycle, away from the edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (acc_valid && q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_cmp++;
                if (pass_sel !== e.pass || cfg_mode !== e.mode ||
                    hid_rdata !== e.rdata || hid_we !== e.we) begin
                    n_bad++;
                    $display("FAIL %s: got pass=%0b mode=%0b rdata=%02h we=%02h exp pass=%0b mode=%0b rdata=%02h we=%02h",
                             e.tag, pass_sel, cfg_mode, hid_rdata, hid_we,
                             e.pass, e.mode, e.rdata, e.we);
                end
            end
        end
    end

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hung run exp completion");
            finish_run();
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) m_reg[i] = 8'h00;
        m_reg[0] = 8'hFF; m_reg[1] = 8'hFF; m_reg[3] = 8'h11; m_reg[5] = 8'h01;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #2;
        n_cmp++;
        if (cfg_mode !== 1'b0 || pass_sel !== 1'b0 || hid_we !== 8'h00) begin
            n_bad++;
            $display("FAIL R1: got mode=%0b pass=%0b we=%02h exp 0 0 00", cfg_mode, pass_sel, hid_we);
        end
        speed_pin = 1'b0;   // pin changes after reset: strap must keep 1 (R6)

        acc(0, 0, 0, 8'h00, "R4 normal read");
        acc(1, 1, 4, 8'h55, "R4 normal write");
        // R3: 8-bit read breaks the sequence
        acc(0, 1, 1, 8'h00, "R4 unlock rd1");
        acc(0, 0, 1, 8'h00, "R3 narrow read");
        acc(1, 0, 2, 8'h03, "R3 key after break");
        acc(0, 0, 3, 8'h00, "R3 still normal");
        // R3: wrong key value
        acc(0, 1, 1, 8'h00, "R3 rd1");
        acc(0, 1, 1, 8'h00, "R3 rd2");
        acc(1, 0, 2, 8'h04, "R3 wrong key");
        acc(1, 0, 2, 8'h03, "R3 key after wrong");
        acc(0, 0, 0, 8'h00, "R3 still normal 2");
        // R2: good unlock, back-to-back with redirected reads
        acc(0, 1, 1, 8'h00, "R2 rd1");
        acc(0, 1, 1, 8'h00, "R2 rd2");
        acc(1, 0, 2, 8'h03, "R2 key");
        acc(0, 0, 0, 8'h00, "R1 rd timing reset");
        acc(0, 0, 1, 8'h00, "R1 wr timing reset");
        acc(0, 0, 3, 8'h00, "R1 ctrl reset");
        acc(0, 0, 5, 8'h00, "R1 strap reset");
        acc(0, 0, 6, 8'h00, "R1 misc reset");
        acc(0, 0, 2, 8'h00, "R9 read off2");
        acc(0, 0, 4, 8'h00, "R9 read off4");
        acc(0, 0, 7, 8'h00, "R9 read off7");
        // writes
        acc(1, 0, 0, 8'h5A, "R5 write rd timing");
        acc(1, 1, 1, 8'hA5, "R5 write wr timing");
        acc(1, 0, 3, 8'h95, "R5 write ctrl enable");
        acc(1, 0, 6, 8'hFF, "R7 write misc");
        acc(1, 0, 5, 8'hFE, "R6 write strap");
        acc(1, 0, 4, 8'h12, "R9 write off4");
        acc(1, 0, 7, 8'h34, "R9 write off7");
        acc(1, 0, 2, 8'h03, "R8 key in mode");
        acc(1, 1, 2, 8'h83, "R8 wide exit ignored");
        acc(0, 0, 0, 8'h00, "R5 read rd timing");
        acc(0, 1, 1, 8'h00, "R5 read wr timing");
        acc(0, 0, 3, 8'h00, "R5 read ctrl");
        acc(0, 0, 6, 8'h00, "R7 read misc");
        acc(0, 0, 5, 8'h00, "R6 read strap");
        acc(0, 0, 4, 8'h00, "R9 read off4 after write");
        acc(0, 0, 7, 8'h00, "R9 read off7 after write");
        acc(1, 0, 3, 8'h11, "R5 write ctrl disable");
        acc(0, 0, 3, 8'h00, "R5 read ctrl disable");
        // R8: exit, then next access passes straight through
        acc(1, 0, 2, 8'h83, "R8 exit");
        acc(0, 0, 0, 8'h00, "R8 normal after exit");
        acc(1, 0, 0, 8'h77, "R4 write not stored");
        // R2: three reads still unlock
        idle();
        acc(0, 1, 1, 8'h00, "R2 rd1b");
        acc(0, 1, 1, 8'h00, "R2 rd2b");
        acc(0, 1, 1, 8'h00, "R2 rd3b");
        acc(1, 0, 2, 8'h03, "R2 key b");
        acc(0, 0, 6, 8'h00, "R7 misc kept");
        acc(0, 0, 0, 8'h00, "R4 rd timing kept");
        acc(1, 0, 2, 8'h83, "R8 exit b");
        acc(0, 0, 6, 8'h00, "R8 normal after exit b");
        idle();
        idle();
        done = 1;
        if (q.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard: got %0d left exp 0", q.size());
        end
        finish_run();
    end

endmodule